// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block sits on a CPU's 24-bit address bus and decides, for every bus cycle, whether the access targets a relocatable 4 KiB window that holds the on-chip peripheral registers. The position of the window comes from a 16-bit base register that software programs through a fixed, never-moving address. Until that register has been written at least once after reset, the window is closed and no address selects the peripherals. When the window is open, the block raises a peripheral-select strobe and presents the 12-bit offset of the access inside the window.

A second fixed-address register holds a sticky conflict flag and a conflict-enable bit. A conflict is an external device acknowledging a cycle that the block has already decoded as an internal peripheral access. Such a cycle sets the flag. When the enable bit is on, the same cycle is ended with a bus error instead of a normal acknowledge. Both fixed registers stay reachable wherever the window has been placed, and they take precedence over the window.

Each cycle with the request input high counts as one access, and the block decodes it combinationally in that cycle. Register updates take effect at the closing clock edge.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset the window is closed and the conflict flag, the conflict-enable bit and the base register all read 0. No access asserts `periphSel` or `busErr`, even when `extAck` is high.
- R2: A write at address 0x0000F2 with function code 3'b101 (supervisor data) loads `busWdata` into the base register and opens the window. A later read at 0x0000F2 returns the stored value on `rdData`.
- R3: A write at 0x0000F2 with any function code other than 3'b101 leaves the base register unchanged and does not open the window.
- R4: `periphSel` is 1 exactly when `busReq` is 1, the window is open, address bits 23:12 equal base register bits 15:4, and the address is neither 0x0000F2 nor 0x0000F4. This decode ignores the function code and the direction of the access. `periphOffset` always equals address bits 11:0.
- R5: Both fixed registers answer at their addresses whatever the base register holds, including when the window covers them. A read asserts `regHit`, never `periphSel`, and drives the register onto `rdData`. Cycles that read no fixed register drive 0.
- R6: A cycle with `periphSel` and `extAck` both high sets the conflict flag at the closing edge. Control-register bit 0 and the `conflictStatus` output report this flag. An `extAck` outside the window does not set it, and once set the flag stays set.
- R7: A supervisor-data write at 0x0000F4 loads bit 1 into the conflict-enable bit. The same write clears the conflict flag when bit 0 is 1 and leaves it unchanged when bit 0 is 0.
- R8: `busErr` is 1 in the same cycle exactly when `periphSel`, `extAck` and the conflict-enable bit are all 1. With the enable bit at 0, a conflict sets the flag but gives no bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset |
| busReq | input | 1 | A bus cycle is present this clock |
| busAddr | input | 24 | Byte address of the cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busFc | input | 3 | Function code of the cycle, 3'b101 is supervisor data |
| busWdata | input | 16 | Write data |
| extAck | input | 1 | Acknowledge from an external device |
| periphSel | output | 1 | Access falls inside the open peripheral window |
| periphOffset | output | 12 | Byte offset inside the window |
| regHit | output | 1 | Access targets the base or the control register |
| rdData | output | 16 | Read data of the fixed registers, 0 otherwise |
| busErr | output | 1 | End the cycle with a bus error |
| conflictStatus | output | 1 | Sticky address-decode-conflict flag |

## Verification
The assertions assume that inputs change only away from the clock edge and that each clock with `busReq` high is a complete, self-contained access. They also assume that `extAck` has meaning only during such an access. The bench drives every input at the falling edge through a single access task or idle task, so each cycle carries exactly one access or none. The conflict-flag properties assume that a clearing write and a window access never share a cycle, which the single bus guarantees. The stimulus respects this because every access is issued as one task call.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // Bit positions inside the control register
  localparam int STAT_BIT = 0;
  localparam int EN_BIT   = 1;

  // Strobes from decode control to the register datapath
  typedef struct packed {
    logic baseWr;
    logic ctrlWr;
    logic rdBase;
    logic rdCtrl;
    logic conflictSet;
  } strobe_t;
endpackage

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 12,
  parameter int FC_W     = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0000F2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0000F4,
  parameter logic [FC_W-1:0]   SUP_FC    = 3'b101,
  localparam int TAG_W = ADDR_W - WIN_BITS
) (
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [FC_W-1:0]   busFc,
  input  logic              extAck,
  input  logic [TAG_W-1:0]  baseTag,
  input  logic              baseValid,
  input  logic              conflictEn,
  output strobe_t           strb,
  output logic              periphSel,
  output logic              regHit,
  output logic              busErr
);
  logic hitBase, hitCtrl, supData, tagMatch;

  always_comb begin
    hitBase  = (busAddr == BASE_ADDR);
    hitCtrl  = (busAddr == CTRL_ADDR);
    supData  = (busFc == SUP_FC);
    tagMatch = (busAddr[ADDR_W-1:WIN_BITS] == baseTag);

    regHit    = busReq && (hitBase || hitCtrl);
    // fixed registers win over the window
    periphSel = busReq && baseValid && tagMatch && !(hitBase || hitCtrl);
    busErr    = periphSel && extAck && conflictEn;

    strb.baseWr      = busReq && busWrite && supData && hitBase;
    strb.ctrlWr      = busReq && busWrite && supData && hitCtrl;
    strb.rdBase      = busReq && !busWrite && hitBase;
    strb.rdCtrl      = busReq && !busWrite && hitCtrl;
    strb.conflictSet = periphSel && extAck;
  end
endmodule

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] baseReg,
  output logic              baseValid,
  output logic              conflictEn,
  output logic              conflictStatus,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg        <= '0;
      baseValid      <= 1'b0;
      conflictEn     <= 1'b0;
      conflictStatus <= 1'b0;
    end else begin
      if (strb.baseWr) begin
        baseReg   <= busWdata;
        baseValid <= 1'b1;
      end
      if (strb.ctrlWr) conflictEn <= busWdata[EN_BIT];
      // a fresh conflict outranks a clearing write
      if (strb.conflictSet)
        conflictStatus <= 1'b1;
      else if (strb.ctrlWr && busWdata[STAT_BIT])
        conflictStatus <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdBase) begin
      rdData = baseReg;
    end else if (strb.rdCtrl) begin
      rdData[STAT_BIT] = conflictStatus;
      rdData[EN_BIT]   = conflictEn;
    end
  end
endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 12,
  parameter int FC_W     = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0000F2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0000F4,
  parameter logic [FC_W-1:0]   SUP_FC    = 3'b101
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [FC_W-1:0]     busFc,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                extAck,
  output logic                periphSel,
  output logic [WIN_BITS-1:0] periphOffset,
  output logic                regHit,
  output logic [DATA_W-1:0]   rdData,
  output logic                busErr,
  output logic                conflictStatus
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  strobe_t           strb;
  logic [DATA_W-1:0] baseReg;
  logic [TAG_W-1:0]  baseTag;
  logic              baseValid;
  logic              conflictEn;

  assign baseTag      = baseReg[DATA_W-1 -: TAG_W];
  assign periphOffset = busAddr[WIN_BITS-1:0];

  pwd_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .FC_W(FC_W),
    .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR), .SUP_FC(SUP_FC)
  ) u_ctrl (
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite), .busFc(busFc),
    .extAck(extAck), .baseTag(baseTag), .baseValid(baseValid),
    .conflictEn(conflictEn), .strb(strb), .periphSel(periphSel),
    .regHit(regHit), .busErr(busErr)
  );

  pwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .baseReg(baseReg), .baseValid(baseValid), .conflictEn(conflictEn),
    .conflictStatus(conflictStatus), .rdData(rdData)
  );
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0000F2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0000F4,
  parameter logic [FC_W-1:0]   SUP_FC    = 3'b101
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [FC_W-1:0]   busFc,
  input logic              clrBit,
  input logic              extAck,
  input logic              periphSel,
  input logic              regHit,
  input logic              busErr,
  input logic              conflictStatus,
  input logic              baseValid,
  input logic              conflictEn,
  input logic [DATA_W-1:0] baseReg
);
  logic clrWrite, badBaseWrite;
  assign clrWrite = busReq && busWrite && (busFc == SUP_FC) &&
                    (busAddr == CTRL_ADDR) && clrBit;
  assign badBaseWrite = busReq && busWrite && (busFc != SUP_FC) &&
                        (busAddr == BASE_ADDR);

  assert_sel_needs_base_R4: assert property (@(posedge clk) disable iff (!rstN)
    periphSel |-> baseValid);

  assert_reg_over_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    regHit |-> !periphSel);

  assert_bad_fc_no_update_R3: assert property (@(posedge clk) disable iff (!rstN)
    badBaseWrite |=> $stable(baseReg));

  assert_conflict_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (periphSel && extAck) |=> conflictStatus);

  assert_conflict_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (conflictStatus && !clrWrite) |=> conflictStatus);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !(periphSel && extAck)) |=> !conflictStatus);

  assert_buserr_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (conflictEn && periphSel && extAck));
endmodule

bind periph_window_decoder pwd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W),
  .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR), .SUP_FC(SUP_FC)
) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
  .busWrite(busWrite), .busFc(busFc), .clrBit(busWdata[0]), .extAck(extAck),
  .periphSel(periphSel), .regHit(regHit), .busErr(busErr),
  .conflictStatus(conflictStatus), .baseValid(baseValid),
  .conflictEn(conflictEn), .baseReg(baseReg)
);

// File: tb/tb_periph_window_decoder.sv
module tb_periph_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] A_BASE = 24'h0000F2;
  localparam logic [23:0] A_CTRL = 24'h0000F4;
  localparam logic [2:0]  FC_SD  = 3'b101;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0, extAck = 1'b0;
  logic [23:0] busAddr = '0;
  logic [2:0]  busFc = '0;
  logic [15:0] busWdata = '0;
  logic        periphSel, regHit, busErr, conflictStatus;
  logic [11:0] periphOffset;
  logic [15:0] rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_window_decoder dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr),
    .busWrite(busWrite), .busFc(busFc), .busWdata(busWdata), .extAck(extAck),
    .periphSel(periphSel), .periphOffset(periphOffset), .regHit(regHit),
    .rdData(rdData), .busErr(busErr), .conflictStatus(conflictStatus)
  );

  typedef struct {
    string       req;
    logic        sel;
    logic [11:0] off;
    logic        hit;
    logic [15:0] rd;
    logic        err;
    logic        conf;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  // reference model state
  logic [15:0] mBase = '0;
  logic        mValid = 1'b0, mEn = 1'b0, mConf = 1'b0;

  task automatic chk(string what, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(string req, logic [23:0] addr, logic wr, logic [2:0] fc,
                        logic [15:0] wd, logic ack);
    exp_t e;
    logic isReg;
    @(negedge clk);
    busReq = 1'b1; busAddr = addr; busWrite = wr; busFc = fc;
    busWdata = wd; extAck = ack;
    isReg  = (addr == A_BASE) || (addr == A_CTRL);
    e.req  = req;
    e.sel  = mValid && (addr[23:12] == mBase[15:4]) && !isReg;
    e.off  = addr[11:0];
    e.hit  = isReg;
    e.rd   = (!wr && addr == A_BASE) ? mBase :
             (!wr && addr == A_CTRL) ? {14'b0, mEn, mConf} : 16'h0;
    e.err  = e.sel && ack && mEn;
    e.conf = mConf;
    q.push_back(e);
    if (wr && fc == FC_SD && addr == A_BASE) begin mBase = wd; mValid = 1'b1; end
    if (wr && fc == FC_SD && addr == A_CTRL) begin
      mEn = wd[1];
      if (wd[0]) mConf = 1'b0;
    end
    if (e.sel && ack) mConf = 1'b1;
  endtask

  task automatic idle(string req);
    exp_t e;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0; extAck = 1'b0;
    e.req = req; e.sel = 1'b0; e.off = busAddr[11:0]; e.hit = 1'b0;
    e.rd = 16'h0; e.err = 1'b0; e.conf = mConf;
    q.push_back(e);
  endtask

  // monitor: compare outputs in the middle of the low phase
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("periphSel", e.req, {15'b0, periphSel}, {15'b0, e.sel});
        chk("periphOffset", e.req, {4'b0, periphOffset}, {4'b0, e.off});
        chk("regHit", e.req, {15'b0, regHit}, {15'b0, e.hit});
        chk("rdData", e.req, rdData, e.rd);
        chk("busErr", e.req, {15'b0, busErr}, {15'b0, e.err});
        chk("conflictStatus", e.req, {15'b0, conflictStatus}, {15'b0, e.conf});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held quiet during reset
    busReq = 1'b1; busAddr = 24'h000100; extAck = 1'b1;
    #(CLK_PERIOD/4);
    chk("periphSel in reset", "R1", {15'b0, periphSel}, 16'h0);
    chk("busErr in reset", "R1", {15'b0, busErr}, 16'h0);
    busReq = 1'b0; extAck = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // R1: window closed after reset, registers zero
    access("R1", A_BASE, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R1", A_CTRL, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R1", 24'h000100, 1'b0, FC_SD, 16'h0, 1'b1);
    idle("R1");

    // R3: wrong function codes do not program the base
    access("R3", A_BASE, 1'b1, 3'b001, 16'h1230, 1'b0);
    access("R3", A_BASE, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R3", 24'h123040, 1'b0, FC_SD, 16'h0, 1'b1);

    // R2: supervisor data write opens the window
    access("R2", A_BASE, 1'b1, FC_SD, 16'hABC0, 1'b0);
    access("R2", A_BASE, 1'b0, 3'b001, 16'h0, 1'b0);

    // R4: window decode edges, fc and direction ignored
    access("R4", 24'hABC123, 1'b0, 3'b010, 16'h0, 1'b0);
    access("R4", 24'hABC000, 1'b1, FC_SD, 16'h5555, 1'b0);
    access("R4", 24'hABCFFF, 1'b0, 3'b110, 16'h0, 1'b0);
    access("R4", 24'hABD000, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R4", 24'hABBFFF, 1'b0, FC_SD, 16'h0, 1'b0);
    idle("R4");

    // R3: supervisor program space also rejected
    access("R3", A_BASE, 1'b1, 3'b110, 16'h5550, 1'b0);
    access("R3", A_BASE, 1'b0, FC_SD, 16'h0, 1'b0);

    // R6: external ack outside window is no conflict
    access("R6", 24'h100000, 1'b0, FC_SD, 16'h0, 1'b1);
    idle("R6");
    // R6: conflict inside window, flag sticks
    access("R6", 24'hABC010, 1'b0, FC_SD, 16'h0, 1'b1);
    idle("R6");
    access("R6", 24'hABC020, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R6", A_CTRL, 1'b0, FC_SD, 16'h0, 1'b0);

    // R7: writing 0 keeps flag, enabling keeps flag, writing 1 clears
    access("R7", A_CTRL, 1'b1, FC_SD, 16'h0000, 1'b0);
    access("R7", A_CTRL, 1'b1, FC_SD, 16'h0002, 1'b0);
    access("R7", A_CTRL, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R7", A_CTRL, 1'b1, 3'b001, 16'h0001, 1'b0);
    access("R7", A_CTRL, 1'b1, FC_SD, 16'h0003, 1'b0);
    access("R7", A_CTRL, 1'b0, FC_SD, 16'h0, 1'b0);

    // R8: enabled conflict raises bus error in the same cycle
    access("R8", 24'hABC400, 1'b0, FC_SD, 16'h0, 1'b1);
    access("R8", 24'hABC400, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R8", 24'h200400, 1'b0, FC_SD, 16'h0, 1'b1);
    // R8: disabled gives flag only
    access("R8", A_CTRL, 1'b1, FC_SD, 16'h0001, 1'b0);
    access("R8", 24'hABC800, 1'b0, FC_SD, 16'h0, 1'b1);
    idle("R8");

    // R5: window moved over the fixed registers
    access("R5", A_BASE, 1'b1, FC_SD, 16'h0000, 1'b0);
    access("R5", A_BASE, 1'b0, FC_SD, 16'h0, 1'b1);
    access("R5", A_CTRL, 1'b0, FC_SD, 16'h0, 1'b1);
    access("R5", 24'h000010, 1'b0, FC_SD, 16'h0, 1'b0);
    access("R5", 24'h0000F0, 1'b0, FC_SD, 16'h0, 1'b0);
    idle("R5");
    idle("R5");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule